// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Carry and Overflow Flags

This block is a purely combinational integer ALU for a processor execute stage. It takes two operands of `WIDTH` bits (32 by default) and a 4-bit operation code. It returns a result word, a carry flag and a signed-overflow flag in the same cycle.

A single adder serves every arithmetic operation. For subtraction, B is inverted bit by bit and the adder's carry-in is forced high. The same adder serves the overflow-checked signed add and subtract, and the unsigned add and subtract, which never raise overflow. Both set-less-than forms take their answer from the subtraction that this adder produces. The four bitwise operations use a separate small logic unit.

The block only raises the overflow flag. The surrounding pipeline decides whether to trap on it.

Top module: `int_alu`

## Requirements
- R1: Codes 0000 (signed add) and 0001 (unsigned add) give result = (A + B) mod 2^WIDTH, and carry = the adder carry-out.
- R2: Codes 0010 (signed subtract) and 0011 (unsigned subtract) give result = (A - B) mod 2^WIDTH, computed as A + ~B + 1. Carry is the carry-out of that sum, so carry is 1 exactly when A >= B as unsigned numbers.
- R3: Under code 0000, overflow is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it. Operands of opposite sign never overflow.
- R4: Under code 0010, overflow is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R5: Overflow is 0 for every code other than 0000 and 0010, including the unsigned add and subtract.
- R6: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, A XOR B and NOT(A OR B), respectively.
- R7: Code 1000 gives 1 when A < B as two's-complement numbers and 0 otherwise. This holds even when A - B overflows.
- R8: Code 1001 gives 1 when A < B as unsigned numbers and 0 otherwise.
- R9: Codes 1010 through 1111 give a zero result, with carry and overflow both 0.
- R10: Carry is 0 for every code outside 0000 to 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| mode_i | input | 4 | Operation code |
| result_o | output | WIDTH | Operation result |
| carry_o | output | 1 | Adder carry-out for the add and subtract codes, else 0 |
| ovf_o | output | 1 | Signed overflow for the signed add and subtract codes, else 0 |

## Verification
The bench builds two copies of the block: one at the default WIDTH of 32 and one at WIDTH of 8. The 32-bit copy is driven with directed values at the sign and carry boundaries: the most negative value, the most positive value, all ones and zero. These cover both overflow directions and both set-less-than forms when the subtraction overflows.

The 8-bit copy makes a dense strided sweep over both operands affordable for all sixteen codes. At that width every mix of operand signs, every carry case and every overflow case is reached many times. The results are compared with a reference that works in wide signed integers instead of bit operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9
  } alu_op_e;

  // Codes that route B through the inverter with carry-in high.
  function automatic logic op_uses_sub(logic [3:0] code);
    return (code == OP_SUB) || (code == OP_SUBU) ||
           (code == OP_SLT) || (code == OP_SLTU);
  endfunction

  // Codes whose carry flag reflects the adder.
  function automatic logic op_is_arith(logic [3:0] code);
    return code[3:2] == 2'b00;
  endfunction

  // Codes allowed to report signed overflow.
  function automatic logic op_flags_ovf(logic [3:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  function automatic logic [WIDTH:0] add_with_cin(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             ci
  );
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  always_comb begin
    b_eff = b_i ^ {WIDTH{sub_i}};
    wide  = add_with_cin(a_i, b_eff, sub_i);
  end

  assign sum_o  = wide[MSB:0];
  assign cout_o = wide[WIDTH];
  // Sign rule on the adder's own inputs; carry-out plays no part.
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

  always_comb begin
    if (ovf_o) begin
      assert_ovf_operand_signs_R3: assert (sub_i ? (a_i[MSB] != b_i[MSB])
                                                 : (a_i[MSB] == b_i[MSB]))
        else $error("overflow with operand signs that cannot overflow");
    end
    if (sub_i) begin
      assert_sub_carry_R2: assert (cout_o == (a_i >= b_i))
        else $error("subtract carry does not match unsigned compare");
    end
  end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      2'b00:   y_o = a_i & b_i;
      2'b01:   y_o = a_i | b_i;
      2'b10:   y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       mode_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] adder_sum;
  logic             adder_cout;
  logic             adder_ovf;
  logic             use_sub;
  logic [WIDTH-1:0] logic_y;
  logic             less_signed;
  logic             less_unsigned;

  assign use_sub = op_uses_sub(mode_i);

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (use_sub),
    .sum_o  (adder_sum),
    .cout_o (adder_cout),
    .ovf_o  (adder_ovf)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (mode_i[1:0]),
    .y_o  (logic_y)
  );

  // Sign of A - B corrected by its overflow; borrow is the inverted carry.
  assign less_signed   = adder_sum[MSB] ^ adder_ovf;
  assign less_unsigned = ~adder_cout;

  always_comb begin
    result_o = '0;
    case (mode_i)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = adder_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result_o = logic_y;
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, less_signed};
      OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, less_unsigned};
      default: result_o = '0;
    endcase
  end

  assign carry_o = op_is_arith(mode_i) & adder_cout;
  assign ovf_o   = op_flags_ovf(mode_i) & adder_ovf;

  always_comb begin
    if (!(mode_i == 4'd0 || mode_i == 4'd2)) begin
      assert_no_overflow_R5: assert (!ovf_o)
        else $error("overflow raised outside signed add/subtract");
    end
    if (mode_i[3:2] != 2'b00) begin
      assert_carry_quiet_R10: assert (!carry_o)
        else $error("carry raised outside add/subtract");
    end
    if (mode_i == 4'd8 || mode_i == 4'd9) begin
      assert_compare_is_bool_R7: assert (result_o[MSB:1] == '0)
        else $error("compare result wider than one bit");
    end
    if (mode_i >= 4'd10) begin
      assert_unused_code_zero_R9: assert (result_o == '0 && !carry_o && !ovf_o)
        else $error("unused code produced nonzero output");
    end
  end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int W  = 32;
  localparam int WN = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]  a, b, res;
  logic [3:0]    mode;
  logic          cy, ov;
  logic [WN-1:0] an, bn, resn;
  logic [3:0]    moden;
  logic          cyn, ovn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int_alu #(.WIDTH(W)) u_int_alu (
    .a_i(a), .b_i(b), .mode_i(mode),
    .result_o(res), .carry_o(cy), .ovf_o(ov));

  int_alu #(.WIDTH(WN)) u_int_alu_narrow (
    .a_i(an), .b_i(bn), .mode_i(moden),
    .result_o(resn), .carry_o(cyn), .ovf_o(ovn));

  // Reference model working in wide integers.
  task automatic model(input longint ua, input longint ub, input int code,
                       input int w, output longint r, output bit c, output bit v);
    longint span, half, sa, sb, full, sres;
    span = longint'(1) << w;
    half = longint'(1) << (w - 1);
    sa = (ua >= half) ? ua - span : ua;
    sb = (ub >= half) ? ub - span : ub;
    r = 0; c = 0; v = 0;
    case (code)
      0, 1: begin
        full = ua + ub; r = full % span; c = (full >= span);
        sres = sa + sb;
        if (code == 0) v = (sres >= half) || (sres < -half);
      end
      2, 3: begin
        full = ua + (span - 1 - ub) + 1; r = full % span; c = (full >= span);
        sres = sa - sb;
        if (code == 2) v = (sres >= half) || (sres < -half);
      end
      4: r = ua & ub;
      5: r = ua | ub;
      6: r = ua ^ ub;
      7: r = (span - 1) - (ua | ub);
      8: r = (sa < sb) ? 1 : 0;
      9: r = (ua < ub) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  task automatic check(input string tag, input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic [3:0] code);
    longint er; bit ec, ev;
    @(negedge clk);
    a = ia; b = ib; mode = code;
    #1;
    model(longint'(ia), longint'(ib), int'(code), W, er, ec, ev);
    checks++;
    if (res !== er[W-1:0] || cy !== ec || ov !== ev) begin
      errors++;
      $display("FAIL %s code=%0d a=%h b=%h got res=%h c=%b v=%b exp res=%h c=%b v=%b",
               tag, code, ia, ib, res, cy, ov, er[W-1:0], ec, ev);
    end
  endtask

  task automatic check_narrow(input string tag, input int ia, input int ib, input int code);
    longint er; bit ec, ev;
    @(negedge clk);
    an = ia[WN-1:0]; bn = ib[WN-1:0]; moden = code[3:0];
    #1;
    model(longint'(ia), longint'(ib), code, WN, er, ec, ev);
    checks++;
    if (resn !== er[WN-1:0] || cyn !== ec || ovn !== ev) begin
      errors++;
      $display("FAIL %s code=%0d a=%h b=%h got res=%h c=%b v=%b exp res=%h c=%b v=%b",
               tag, code, an, bn, resn, cyn, ovn, er[WN-1:0], ec, ev);
    end
  endtask

  task automatic test_idle_state();
    check("R1 idle zero operands", 32'h0, 32'h0, 4'd0);
  endtask

  task automatic test_add();
    check("R1 add plain", 32'd1234, 32'd4321, 4'd0);
    check("R1 addu wraps with carry", 32'hFFFF_FFFF, 32'h1, 4'd1);
    check("R1 add carry without overflow", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0);
    check("R3 add positive overflow", 32'h7FFF_FFFF, 32'h1, 4'd0);
    check("R3 add negative overflow", 32'h8000_0000, 32'h8000_0000, 4'd0);
    check("R3 mixed signs never overflow", 32'h7FFF_FFFF, 32'h8000_0000, 4'd0);
    check("R5 addu silent on overflow", 32'h7FFF_FFFF, 32'h1, 4'd1);
  endtask

  task automatic test_sub();
    check("R2 sub plain", 32'd500, 32'd20, 4'd2);
    check("R2 sub borrow", 32'h0, 32'h1, 4'd2);
    check("R2 subu equal operands", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd3);
    check("R4 sub overflow low", 32'h8000_0000, 32'h1, 4'd2);
    check("R4 sub overflow high", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd2);
    check("R5 subu silent on overflow", 32'h8000_0000, 32'h1, 4'd3);
  endtask

  task automatic test_logic();
    for (int k = 4; k < 8; k++) begin
      check("R6 bitwise pattern A", 32'hF0F0_A5A5, 32'h0FF0_5AA5, 4'(k));
      check("R6 bitwise pattern B", 32'h0, 32'hFFFF_FFFF, 4'(k));
    end
    check("R10 carry quiet on logic", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd4);
  endtask

  task automatic test_compare();
    check("R7 slt most negative vs one", 32'h8000_0000, 32'h1, 4'd8);
    check("R7 slt max vs minus one", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd8);
    check("R7 slt equal", 32'h5, 32'h5, 4'd8);
    check("R7 slt minus two vs minus one", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'd8);
    check("R8 sltu small vs all ones", 32'h1, 32'hFFFF_FFFF, 4'd9);
    check("R8 sltu most negative vs one", 32'h8000_0000, 32'h1, 4'd9);
    check("R8 sltu equal", 32'h9, 32'h9, 4'd9);
  endtask

  task automatic test_unused();
    for (int k = 10; k < 16; k++)
      check("R9 unused code", 32'hFFFF_FFFF, 32'h1, 4'(k));
  endtask

  task automatic test_narrow_sweep();
    for (int x = 0; x < 256; x += 9)
      for (int y = 0; y < 256; y += 9)
        for (int k = 0; k < 16; k++)
          check_narrow("R1 R2 R3 R4 R7 R8 narrow sweep", x, y, k);
    check_narrow("R3 narrow positive edge", 8'h7F, 8'h01, 0);
    check_narrow("R4 narrow negative edge", 8'h80, 8'h01, 2);
  endtask

  initial begin
    a = '0; b = '0; mode = '0;
    an = '0; bn = '0; moden = '0;
    repeat (2) @(posedge clk);
    test_idle_state();
    test_add();
    test_sub();
    test_logic();
    test_compare();
    test_unused();
    test_narrow_sweep();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule